// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block turns the fill counts of a UART's receive and transmit FIFOs into a live status word and keeps a sticky interrupt register with a mask in front of one level interrupt line. Each cycle it compares both counts against empty, full and a programmable trigger level. The resulting conditions are ORed into the sticky register, together with single-cycle error pulses from the receive and transmit paths.

Software reads both words through a small register port. It clears sticky bits by writing ones to them. It changes the mask only through a set register and a clear register. The interrupt output stays high while any sticky bit is also enabled in the mask. The FIFOs, the shift logic and the baud generation sit outside this block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The live status word carries five FIFO conditions: bit 0 is RX count >= RX trigger level, bit 1 is RX count == 0, bit 2 is RX count == DEPTH, bit 3 is TX count == 0, and bit 4 is TX count == DEPTH.
- R2: The TX count >= TX trigger level condition is bit 13 of the live status word and bit 10 of the sticky register. Live bit 10 and sticky bit 13 stay zero.
- R3: On every clock edge after reset, live bits 0 to 4 and the TX trigger condition are ORed into the sticky register. A sticky bit stays set after its condition goes away.
- R4: Single-cycle event pulses set sticky bits one clock later: RX overrun sets bit 5, framing error bit 6, parity error bit 7, receive timeout bit 8, modem status bit 9 and TX overflow bit 12.
- R5: A write to the sticky register (address 3) clears every bit written as one. Bits written as zero keep their value.
- R6: A write to address 0 ORs the data into the mask, and a write to address 1 clears the mask bits written as one. A write to the mask read address (2) leaves the mask unchanged.
- R7: The irq output is high exactly when some bit is set in both the mask and the sticky register.
- R8: While rst_n is low at a clock edge, the mask and the sticky register become zero and both trigger levels become 32. The irq output is then low.
- R9: An event pulse or a live condition in the same cycle as a write that clears its bit leaves that bit set.
- R10: The RX and TX trigger levels are written and read back at addresses 4 and 5. The live word is read at address 6, and address 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO fill count |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_overflow | input | 1 | Transmit overflow pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the count inputs never exceed DEPTH and that every event input is a one-cycle pulse. They also assume that only one register write is presented per cycle. The stimulus drives counts only in the range 0 to 64 with the default depth. It raises each event for exactly one clock. It issues writes one at a time, driven between clock edges, so the overlap of a clearing write with an event in R9 is the only deliberate collision.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
// Package: shared register selects and bit positions for the UART interrupt unit.
// Assumes DATA_W of the users is at least MIN_DATA_W so every position fits.
package uirq_pkg;
    typedef enum logic [2:0] {
        SEL_MASK_SET = 3'd0,
        SEL_MASK_CLR = 3'd1,
        SEL_MASK     = 3'd2,
        SEL_STICKY   = 3'd3,
        SEL_RX_LVL   = 3'd4,
        SEL_TX_LVL   = 3'd5,
        SEL_LIVE     = 3'd6
    } reg_sel_e;

    localparam int LV_RX_LVL   = 0;
    localparam int LV_RX_EMPTY = 1;
    localparam int LV_RX_FULL  = 2;
    localparam int LV_TX_EMPTY = 3;
    localparam int LV_TX_FULL  = 4;
    localparam int LV_TX_LVL   = 13;
    localparam int ST_TX_LVL   = 10;
    localparam int FIFO_FLAGS  = 5;

    localparam int NUM_EV = 6;
    // event order: rx overrun, framing, parity, rx timeout, modem, tx overflow
    localparam int EV_POS [NUM_EV] = '{5, 6, 7, 8, 9, 12};

    localparam int MIN_DATA_W = 14;
endpackage

// File: rtl/uirq_live_status.sv
`timescale 1ns/1ps
// Module: uirq_live_status
// Builds the live FIFO status word from the two fill counts and trigger levels.
// Assumes counts never exceed DEPTH; purely combinational.
module uirq_live_status
    import uirq_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int DATA_W = 16
) (
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  tx_level,
    output logic [DATA_W-1:0] live
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // Purpose: compare each count against empty, full and its trigger level.
    always_comb begin
        live               = '0;
        live[LV_RX_LVL]    = (rx_count >= rx_level);
        live[LV_RX_EMPTY]  = (rx_count == '0);
        live[LV_RX_FULL]   = (rx_count == FULL_CNT);
        live[LV_TX_EMPTY]  = (tx_count == '0);
        live[LV_TX_FULL]   = (tx_count == FULL_CNT);
        live[LV_TX_LVL]    = (tx_count >= tx_level);
    end
endmodule

// File: rtl/uirq_cfg_regs.sv
`timescale 1ns/1ps
// Module: uirq_cfg_regs
// Holds the two trigger levels and the interrupt mask. The mask moves only
// through the set and clear selects; its own select is read-only.
// Assumes at most one write per cycle, decoded by the caller.
module uirq_cfg_regs
    import uirq_pkg::*;
#(
    parameter int CNT_W    = 7,
    parameter int DATA_W   = 16,
    parameter int LVL_INIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  rx_level,
    output logic [CNT_W-1:0]  tx_level,
    output logic [DATA_W-1:0] mask
);
    localparam logic [CNT_W-1:0] LVL_RST = CNT_W'(LVL_INIT);

    // Purpose: update the mask through the set/clear selects only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MASK_SET: mask <= mask | wdata;
                SEL_MASK_CLR: mask <= mask & ~wdata;
                default:      mask <= mask;
            endcase
        end
    end

    // Purpose: hold the programmable RX and TX trigger levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_level <= LVL_RST;
            tx_level <= LVL_RST;
        end else if (wr_en) begin
            if (sel == SEL_RX_LVL) rx_level <= wdata[CNT_W-1:0];
            if (sel == SEL_TX_LVL) tx_level <= wdata[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/uirq_sticky.sv
`timescale 1ns/1ps
// Module: uirq_sticky
// Sticky interrupt register: set by live FIFO conditions and event pulses,
// cleared by write-one-to-clear. Setting wins over a clear in the same cycle.
// Assumes event inputs are single-cycle pulses.
module uirq_sticky
    import uirq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_bits,
    input  logic [DATA_W-1:0] live,
    input  logic [NUM_EV-1:0] events,
    output logic [DATA_W-1:0] sticky
);
    logic [DATA_W-1:0] live_map;
    logic [DATA_W-1:0] ev_map;
    logic [DATA_W-1:0] clr_mask;

    // Purpose: move live bits to their sticky positions (TX trigger relocates).
    always_comb begin
        live_map                    = '0;
        live_map[FIFO_FLAGS-1:0]    = live[FIFO_FLAGS-1:0];
        live_map[ST_TX_LVL]         = live[LV_TX_LVL];
    end

    // Purpose: place each event pulse at its sticky bit.
    always_comb begin
        ev_map = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            ev_map[EV_POS[i]] = ev_map[EV_POS[i]] | events[i];
        end
    end

    assign clr_mask = clr_en ? clr_bits : '0;

    // Purpose: clear written ones, then OR in every new set condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= '0;
        end else begin
            sticky <= (sticky & ~clr_mask) | live_map | ev_map;
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
// Module: uart_irq_ctrl (top)
// UART interrupt status and mask unit: live FIFO status, sticky interrupt
// register, set/clear mask, level interrupt, and a combinational read port.
// Assumes DATA_W >= uirq_pkg::MIN_DATA_W and counts never above DEPTH.
module uart_irq_ctrl
    import uirq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int CNT_W    = $clog2(DEPTH + 1),
    parameter int DATA_W   = 16,
    parameter int LVL_INIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              ev_rx_overrun,
    input  logic              ev_frame_err,
    input  logic              ev_parity_err,
    input  logic              ev_rx_timeout,
    input  logic              ev_modem,
    input  logic              ev_tx_overflow,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    reg_sel_e          sel;
    logic [CNT_W-1:0]  rx_level_q;
    logic [CNT_W-1:0]  tx_level_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] sticky_q;
    logic [DATA_W-1:0] live_w;
    logic [NUM_EV-1:0] ev_vec;

    assign sel    = reg_sel_e'(reg_addr);
    assign ev_vec = {ev_tx_overflow, ev_modem, ev_rx_timeout,
                     ev_parity_err, ev_frame_err, ev_rx_overrun};

    uirq_live_status #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_live (
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_level (rx_level_q),
        .tx_level (tx_level_q),
        .live     (live_w)
    );

    uirq_cfg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .LVL_INIT(LVL_INIT)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .sel      (sel),
        .wdata    (reg_wdata),
        .rx_level (rx_level_q),
        .tx_level (tx_level_q),
        .mask     (mask_q)
    );

    uirq_sticky #(.DATA_W(DATA_W)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (reg_wr && (sel == SEL_STICKY)),
        .clr_bits (reg_wdata),
        .live     (live_w),
        .events   (ev_vec),
        .sticky   (sticky_q)
    );

    // Purpose: return the selected register; write-only selects read zero.
    always_comb begin
        case (sel)
            SEL_MASK:   reg_rdata = mask_q;
            SEL_STICKY: reg_rdata = sticky_q;
            SEL_RX_LVL: reg_rdata = DATA_W'(rx_level_q);
            SEL_TX_LVL: reg_rdata = DATA_W'(tx_level_q);
            SEL_LIVE:   reg_rdata = live_w;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = |(mask_q & sticky_q);
endmodule

// File: rtl/uirq_checker.sv
`timescale 1ns/1ps
// Module: uirq_checker
// Temporal checks on the interrupt unit; attached to the top through bind.
// Assumes one-cycle event pulses and at most one write per cycle.
module uirq_checker #(
    parameter int CNT_W  = 7,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [CNT_W-1:0]  rx_count,
    input logic [CNT_W-1:0]  tx_count,
    input logic              ev_rx_overrun,
    input logic              ev_frame_err,
    input logic [CNT_W-1:0]  tx_level,
    input logic [DATA_W-1:0] mask,
    input logic [DATA_W-1:0] sticky,
    input logic              irq
);
    // R1: an empty receive FIFO marks sticky bit 1 on the next edge
    p_rx_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> sticky[1]);

    // R2: TX trigger lands at sticky bit 10, never bit 13
    p_tx_lvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count >= tx_level) |=> (sticky[10] && !sticky[13]));

    // R3: without a sticky write, no set bit drops
    p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 3'd3) |=> ((sticky & $past(sticky)) == $past(sticky)));

    // R4: overrun pulse sets bit 5
    p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_overrun |=> sticky[5]);

    // R6: write to the mask read address leaves the mask alone
    p_mask_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd2) |=> $stable(mask));

    // R7: interrupt level follows mask and sticky overlap
    p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((mask & sticky) != '0));

    // R8: reset clears mask and sticky
    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> (mask == '0 && sticky == '0 && !irq));

    // R9: framing pulse wins over a clear of bit 6
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd3 && reg_wdata[6] && ev_frame_err) |=> sticky[6]);
endmodule

bind uart_irq_ctrl uirq_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .rx_count      (rx_count),
    .tx_count      (tx_count),
    .ev_rx_overrun (ev_rx_overrun),
    .ev_frame_err  (ev_frame_err),
    .tx_level      (tx_level_q),
    .mask          (mask_q),
    .sticky        (sticky_q),
    .irq           (irq)
);

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
// Bench: table walk of live status patterns, then directed sticky/mask/irq tests.
module sim_uart_irq_ctrl;
    localparam int CW = 7;
    localparam int DW = 16;
    localparam logic [2:0] A_MSET = 3'd0, A_MCLR = 3'd1, A_MASK = 3'd2,
                           A_STK = 3'd3, A_RXL = 3'd4, A_TXL = 3'd5,
                           A_LIVE = 3'd6, A_NONE = 3'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] rx_count = '0, tx_count = '0;
    logic ev_ovr = 0, ev_frm = 0, ev_par = 0, ev_tmo = 0, ev_mdm = 0, ev_txo = 0;
    logic reg_wr = 0;
    logic [2:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic irq;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .ev_rx_overrun(ev_ovr), .ev_frame_err(ev_frm), .ev_parity_err(ev_par),
        .ev_rx_timeout(ev_tmo), .ev_modem(ev_mdm), .ev_tx_overflow(ev_txo),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // {rx_count, tx_count, expected live word} with default trigger levels of 32
    localparam logic [29:0] VEC [8] = '{
        {7'd0,  7'd0,  16'h000A},
        {7'd32, 7'd32, 16'h2001},
        {7'd64, 7'd64, 16'h2015},
        {7'd31, 7'd31, 16'h0000},
        {7'd1,  7'd64, 16'h2010},
        {7'd64, 7'd0,  16'h000D},
        {7'd33, 7'd5,  16'h0001},
        {7'd0,  7'd40, 16'h2002}
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic counts(input logic [CW-1:0] r, input logic [CW-1:0] t);
        @(negedge clk);
        rx_count = r; tx_count = t;
        @(negedge clk);
    endtask

    initial begin
        logic [DW-1:0] v;
        // R8: reset state
        repeat (3) @(negedge clk);
        rd(A_MASK, v); chk("R8 mask", v, 16'h0000);
        rd(A_STK, v);  chk("R8 sticky", v, 16'h0000);
        rd(A_RXL, v);  chk("R8 rx level", v, 16'd32);
        rd(A_TXL, v);  chk("R8 tx level", v, 16'd32);
        chk("R8 irq", {15'd0, irq}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_STK, v); chk("R3 first update", v, 16'h000A);

        // R1 R2: live word table walk
        for (int i = 0; i < 8; i++) begin
            rx_count = VEC[i][29:23];
            tx_count = VEC[i][22:16];
            rd(A_LIVE, v);
            chk($sformatf("R1 R2 live vec %0d", i), v, VEC[i][15:0]);
        end

        // R2 R3 R5: TX trigger relocation and stickiness
        counts(7'd10, 7'd40);
        wr(A_STK, 16'hFFFF);
        rd(A_STK, v); chk("R2 sticky bit10", v, 16'h0400);
        rd(A_LIVE, v); chk("R2 live bit13", v, 16'h2000);
        counts(7'd10, 7'd10);
        rd(A_STK, v); chk("R3 held", v, 16'h0400);
        wr(A_STK, 16'h0400);
        rd(A_STK, v); chk("R5 cleared", v, 16'h0000);

        // R4: event positions
        @(negedge clk); ev_ovr = 1; @(negedge clk); ev_ovr = 0;
        rd(A_STK, v); chk("R4 overrun", v, 16'h0020);
        @(negedge clk); ev_frm = 1; @(negedge clk); ev_frm = 0;
        rd(A_STK, v); chk("R4 framing", v, 16'h0060);
        @(negedge clk); ev_par = 1; @(negedge clk); ev_par = 0;
        rd(A_STK, v); chk("R4 parity", v, 16'h00E0);
        @(negedge clk); ev_tmo = 1; @(negedge clk); ev_tmo = 0;
        rd(A_STK, v); chk("R4 timeout", v, 16'h01E0);
        @(negedge clk); ev_mdm = 1; @(negedge clk); ev_mdm = 0;
        rd(A_STK, v); chk("R4 modem", v, 16'h03E0);
        @(negedge clk); ev_txo = 1; @(negedge clk); ev_txo = 0;
        rd(A_STK, v); chk("R4 tx overflow", v, 16'h13E0);

        // R5: partial clear
        wr(A_STK, 16'h0020);
        rd(A_STK, v); chk("R5 partial", v, 16'h13C0);

        // R9: framing pulse coincident with its clear
        @(negedge clk);
        reg_wr = 1; reg_addr = A_STK; reg_wdata = 16'h0040; ev_frm = 1;
        @(negedge clk);
        reg_wr = 0; ev_frm = 0;
        rd(A_STK, v); chk("R9 set wins", v, 16'h13C0);

        // R6: mask set/clear, direct write ignored
        wr(A_MSET, 16'h0041);
        rd(A_MASK, v); chk("R6 set", v, 16'h0041);
        wr(A_MSET, 16'h0400);
        rd(A_MASK, v); chk("R6 set more", v, 16'h0441);
        wr(A_MCLR, 16'h0001);
        rd(A_MASK, v); chk("R6 clear", v, 16'h0440);
        wr(A_MASK, 16'hFFFF);
        rd(A_MASK, v); chk("R6 direct ignored", v, 16'h0440);

        // R7: irq level
        #1; chk("R7 irq high", {15'd0, irq}, 16'h0001);
        wr(A_STK, 16'h0040);
        #1; chk("R7 irq low", {15'd0, irq}, 16'h0000);
        counts(7'd10, 7'd40);
        #1; chk("R7 irq tx trig", {15'd0, irq}, 16'h0001);
        wr(A_MCLR, 16'h0400);
        #1; chk("R7 irq masked off", {15'd0, irq}, 16'h0000);

        // R10: trigger levels and readback map
        wr(A_RXL, 16'd5);
        rd(A_RXL, v); chk("R10 rx level", v, 16'd5);
        rx_count = 7'd5;
        rd(A_LIVE, v); chk("R10 rx at level", v, 16'h2001);
        rx_count = 7'd4;
        rd(A_LIVE, v); chk("R10 rx below", v, 16'h2000);
        wr(A_TXL, 16'd50);
        rd(A_LIVE, v); chk("R10 tx below", v, 16'h0000);
        wr(A_TXL, 16'd0);
        rd(A_LIVE, v); chk("R10 tx level zero", v, 16'h2000);
        rd(A_NONE, v); chk("R10 unused addr", v, 16'h0000);
        rd(A_MSET, v); chk("R10 set addr reads zero", v, 16'h0000);

        // R8: reset mid-run
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        rd(A_RXL, v); chk("R8 rx level again", v, 16'd32);
        rd(A_TXL, v); chk("R8 tx level again", v, 16'd32);
        rd(A_STK, v); chk("R8 sticky again", v, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule